// File: doc/BRIEF.md
# NAND flash bus timing sequencer

This block turns single host requests into pin sequences for a NAND flash device on a shared byte-wide bus. The two top bits of the request address pick the access kind: command, address or data. The block then drives the command latch, the address latch, one of four active-low chip enables, the active-low write and read strobes, and the output enable of the data bus.

Every access runs the same three phases. A setup phase comes first, then a strobe phase, then a hold phase. Cycle-count fields set the length of each phase, and the host holds these fields steady on configuration inputs. Two further fields set the gap from the command or address latch to a read strobe. One more field sets how long the bus stays tristated at the start of a write.

Only one access is in flight at a time. `req_ready` is low from acceptance until the access completes. Completion is marked by a one-cycle `rsp_done`, and on reads `rsp_rdata` carries the byte sampled during the last cycle of the read strobe.

Top module: `nand_seq`

## Requirements
- R1: During reset and after it, every chip enable, `nand_we_n` and `nand_re_n` are high, `nand_cle` and `nand_ale` are low, `nand_dq_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is accepted on a rising edge where `req_ready` and `req_valid` are both high. The window is `req_addr[ADDR_W-1:ADDR_W-2]`: 2'b01 is command and raises `nand_cle`, 2'b10 is address and raises `nand_ale`, and 2'b00 or 2'b11 is data and raises neither. For the whole access, the chip enable `nand_ce_n[b]` is low, where b is `cfg_bank` sampled at acceptance, and all other enables stay high.
- R3: For a write, the setup phase lasts `cfg_tset`+1 cycles, counted from the first cycle after acceptance. The strobe asserts in the cycle after the setup phase ends.
- R4: For a read, the setup phase lasts max(`cfg_tset`, L)+1 cycles. L is `cfg_tclr` when the access is in the command window, or when it is in the data window and the previous access was a command. L is `cfg_tar` in the same two cases for the address window. Otherwise L is 0.
- R5: The strobe lasts at least `cfg_twait`+1 cycles. After that minimum, it ends only on a cycle in which `nand_wait_n` is high.
- R6: After the strobe, the hold phase lasts `cfg_thold`+1 cycles. Both strobes are high during hold, and the latches, the chip enable and the write data stay unchanged.
- R7: On a write, `nand_dq_oe` is low for the first `cfg_thiz` cycles of the access (0 means none). It is then high until the hold phase ends, with `nand_dq_out` equal to the accepted `req_wdata`. On a read, `nand_dq_oe` is never high.
- R8: A read captures `nand_dq_in` on the edge that ends its last strobe cycle. `rsp_rdata` shows the captured byte in the done cycle and holds it until the next read.
- R9: `rsp_done` is high for exactly one cycle, the first cycle after the last hold cycle, and `req_ready` rises in that same cycle. While `req_ready` is low, `req_valid` has no effect.
- R10: A write access drives only `nand_we_n` low, and a read access drives only `nand_re_n` low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Host address; top two bits select window |
| req_wdata | input | DQ_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DQ_W | Last read byte |
| cfg_tclr | input | LW | Command latch to read strobe gap, N+1 |
| cfg_tar | input | LW | Address latch to read strobe gap, N+1 |
| cfg_tset | input | TW | Setup cycles, N+1 |
| cfg_twait | input | TW | Minimum strobe cycles, N+1 |
| cfg_thold | input | TW | Hold cycles, N+1 |
| cfg_thiz | input | TW | Write bus tristate cycles, N |
| cfg_bank | input | BW | Bank to enable |
| nand_wait_n | input | 1 | Low extends the strobe |
| nand_dq_in | input | DQ_W | Bus read value |
| nand_dq_out | output | DQ_W | Bus write value |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | BANKS | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |

## Verification
A wrong phase counter shows at the pins within one cycle, because a strobe edge then moves away from its expected cycle. A stale record of the previous access kind shows only on the next data read, where the read strobe falls earlier or later than it should. A capture on the wrong edge shows in the done cycle as a different byte, since the bench changes the bus value on every cycle of the access. Every pin is compared against the bench model on every cycle, so each of these faults is flagged in the cycle where it first appears.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 16,
  parameter int TW     = 8,
  parameter int LW     = 4,
  parameter int BANKS  = 4,
  localparam int BW    = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_done,
  output logic [DQ_W-1:0]   rsp_rdata,
  input  logic [LW-1:0]     cfg_tclr,
  input  logic [LW-1:0]     cfg_tar,
  input  logic [TW-1:0]     cfg_tset,
  input  logic [TW-1:0]     cfg_twait,
  input  logic [TW-1:0]     cfg_thold,
  input  logic [TW-1:0]     cfg_thiz,
  input  logic [BW-1:0]     cfg_bank,
  input  logic              nand_wait_n,
  input  logic [DQ_W-1:0]   nand_dq_in,
  output logic [DQ_W-1:0]   nand_dq_out,
  output logic              nand_dq_oe,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [BANKS-1:0]  nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;
  localparam logic [1:0] K_DATA = 2'd0, K_CMD = 2'd1, K_ADR = 2'd2;

  st_t             st;
  logic [TW-1:0]   cnt, hiz;
  logic [1:0]      kind, prev;
  logic            wr;
  logic [BW-1:0]   bank;
  logic [DQ_W-1:0] wdat, rdat;
  logic            done;

  logic [1:0]    req_kind, lat_src;
  logic [TW-1:0] lat_n, setup_n;
  logic          busy;

  assign req_kind = (req_addr[ADDR_W-1 -: 2] == 2'b01) ? K_CMD :
                    (req_addr[ADDR_W-1 -: 2] == 2'b10) ? K_ADR : K_DATA;
  assign lat_src  = (req_kind != K_DATA) ? req_kind : prev;
  assign lat_n    = (lat_src == K_CMD) ? TW'(cfg_tclr) :
                    (lat_src == K_ADR) ? TW'(cfg_tar) : '0;
  assign setup_n  = (!req_write && lat_n > cfg_tset) ? lat_n : cfg_tset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      hiz  <= '0;
      kind <= K_DATA;
      prev <= K_DATA;
      wr   <= 1'b0;
      bank <= '0;
      wdat <= '0;
      rdat <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hiz != '0) hiz <= hiz - 1'b1;
      case (st)
        S_IDLE:
          if (req_valid) begin
            st   <= S_SETUP;
            cnt  <= setup_n;
            hiz  <= req_write ? cfg_thiz : '0;
            kind <= req_kind;
            prev <= req_kind;
            wr   <= req_write;
            bank <= cfg_bank;
            wdat <= req_wdata;
          end
        S_SETUP:
          if (cnt == '0) begin
            st  <= S_STRB;
            cnt <= cfg_twait;
          end else cnt <= cnt - 1'b1;
        S_STRB:
          if (cnt == '0 && nand_wait_n) begin
            st  <= S_HOLD;
            cnt <= cfg_thold;
            if (!wr) rdat <= nand_dq_in;
          end else if (cnt != '0) cnt <= cnt - 1'b1;
        default:
          if (cnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign req_ready   = !busy;
  assign rsp_done    = done;
  assign rsp_rdata   = rdat;
  assign nand_cle    = busy && kind == K_CMD;
  assign nand_ale    = busy && kind == K_ADR;
  assign nand_ce_n   = busy ? ~(BANKS'(1) << bank) : '1;
  assign nand_we_n   = !(st == S_STRB && wr);
  assign nand_re_n   = !(st == S_STRB && !wr);
  assign nand_dq_oe  = busy && wr && hiz == '0;
  assign nand_dq_out = wdat;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R10
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n)); // R2
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (nand_ce_n != '1)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9
  AST_NO_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R7
  AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable({nand_cle, nand_ale, nand_ce_n})); // R6
  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> $past(!nand_re_n)); // R8

endmodule

// File: tb/nand_seq_bench.sv
`timescale 1ns/1ps
module nand_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  cfg_tclr = '0, cfg_tar = '0;
  logic [7:0]  cfg_tset = '0, cfg_twait = '0, cfg_thold = '0, cfg_thiz = '0;
  logic [1:0]  cfg_bank = '0;
  logic        nand_wait_n = 1'b1;
  logic [7:0]  nand_dq_in = '0;
  logic        req_ready, rsp_done, nand_dq_oe, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  rsp_rdata, nand_dq_out;
  logic [3:0]  nand_ce_n;

  int checks = 0, errors = 0, cyc = 0;
  bit [1:0] prev_k = 2'd0;

  nand_seq u_nand_seq (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog got %0d exp %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0h exp %0h", tag, t, got, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic access(input logic [1:0] win, input bit wr, input logic [7:0] wd,
                        input int wt, input bit stray);
    bit [1:0] k, src;
    int s, b, h, tot, tl;
    logic [7:0] base;
    k   = (win == 2'b01) ? 2'd1 : (win == 2'b10) ? 2'd2 : 2'd0;
    src = (k != 0) ? k : prev_k;
    tl  = (src == 1) ? int'(cfg_tclr) : (src == 2) ? int'(cfg_tar) : 0;
    s   = wr ? int'(cfg_tset) + 1 : mx(int'(cfg_tset), tl) + 1;
    b   = mx(int'(cfg_twait), wt) + 1;
    h   = int'(cfg_thold) + 1;
    tot = s + b + h;
    base = wd ^ 8'h5a;
    chk("R9 ready before request", -1, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = {win, 14'h0123};
    req_write = wr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = '0;
    req_wdata = ~wd;
    for (int t = 0; t < tot; t++) begin
      bit in_strb;
      string stag;
      in_strb = (t >= s) && (t < s + b);
      if (stray && t == 1) begin
        req_valid = 1'b1;
        req_addr  = 16'h4000;
      end
      if (t == 2) req_valid = 1'b0;
      nand_wait_n = !(in_strb && (t - s) < wt);
      nand_dq_in  = base + 8'(t);
      chk("R2 latches and enables", t, {26'd0, nand_cle, nand_ale, nand_ce_n},
          {26'd0, k == 2'd1, k == 2'd2, ~(4'b0001 << cfg_bank)});
      stag = (t < s) ? (wr ? "R3 setup" : "R4 read setup") : in_strb ? "R5 R10 strobe" : "R6 hold";
      chk(stag, t, {30'd0, nand_we_n, nand_re_n}, {30'd0, !(wr && in_strb), !(!wr && in_strb)});
      chk("R7 output enable", t, {31'd0, nand_dq_oe}, {31'd0, wr && t >= int'(cfg_thiz)});
      if (wr && t >= int'(cfg_thiz)) chk("R7 write data", t, {24'd0, nand_dq_out}, {24'd0, wd});
      chk("R9 busy no done", t, {30'd0, req_ready, rsp_done}, 32'd0);
      @(negedge clk);
    end
    nand_wait_n = 1'b1;
    chk("R9 done with ready", tot, {30'd0, req_ready, rsp_done}, 32'd3);
    chk("R1 idle pins", tot, {23'd0, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe},
        {23'd0, 2'b00, 4'hf, 2'b11, 1'b0});
    if (!wr) chk("R8 read data", tot, {24'd0, rsp_rdata}, {24'd0, base + 8'(s + b - 1)});
    prev_k = k;
    @(negedge clk);
    chk("R9 single pulse", tot + 1, {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset pins", -1, {22'd0, req_ready, rsp_done, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe},
        {22'd0, 1'b1, 1'b0, 2'b00, 4'hf, 2'b11, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", -1, {30'd0, req_ready, nand_dq_oe}, 32'd2);

    cfg_tset = 2; cfg_twait = 1; cfg_thold = 0; cfg_thiz = 1; cfg_bank = 0;
    access(2'b01, 1'b1, 8'h70, 0, 1'b1);
    cfg_tset = 0; cfg_twait = 0; cfg_thold = 2; cfg_thiz = 0; cfg_bank = 2;
    access(2'b10, 1'b1, 8'h3c, 0, 1'b0);
    cfg_tar = 5; cfg_tset = 1; cfg_twait = 1; cfg_bank = 1;
    access(2'b00, 1'b0, 8'h11, 3, 1'b1);
    cfg_tclr = 3; cfg_tset = 0; cfg_twait = 0; cfg_thold = 1; cfg_thiz = 2;
    access(2'b01, 1'b1, 8'h00, 0, 1'b0);
    access(2'b00, 1'b0, 8'h22, 0, 1'b0);
    cfg_tset = 2; cfg_twait = 2; cfg_thold = 0;
    access(2'b00, 1'b0, 8'h33, 5, 1'b1);
    cfg_tclr = 15; cfg_tset = 3; cfg_bank = 3;
    access(2'b01, 1'b0, 8'h44, 0, 1'b0);
    cfg_tset = 1; cfg_twait = 2; cfg_thiz = 6; cfg_thold = 1;
    access(2'b00, 1'b1, 8'ha5, 0, 1'b1);
    cfg_bank = 0; cfg_thiz = 0;
    access(2'b11, 1'b1, 8'h5e, 2, 1'b0);
    cfg_tar = 2; cfg_tset = 4;
    access(2'b10, 1'b0, 8'h66, 0, 1'b0);
    cfg_tset = 255; cfg_twait = 3; cfg_thold = 255; cfg_thiz = 255;
    access(2'b00, 1'b1, 8'h99, 0, 1'b0);
    cfg_tset = 0; cfg_twait = 255; cfg_thold = 0;
    access(2'b00, 1'b0, 8'h77, 300, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule